// File: doc/BRIEF.md
# SMBus Pointer-Register Slave Interface

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronizers clocked by a much faster system clock. It finds bus start, repeated start and stop conditions and decodes the slave address that follows each start. It then moves bytes between the bus and a register bank outside the block. The seven-bit slave address is a fixed six-bit parameter with one strap pin as its lowest bit.

A write transaction first loads an internal pointer with the byte that follows the address. Every later byte of that transaction goes to the register the pointer selects, and the pointer then steps by one. A read transaction returns the register at the pointer. The pointer survives a stop, so a host can set it once and read later with a bare read transaction, or it can use a repeated start in the same transaction. The register bank is reached through a plain address, write-data, write-enable and read-data port, and the read data is taken combinationally. The data line is only ever pulled low, by an output enable.

Top module: `smbp_slave`

## Requirements
- R1: While reset is held and on the first cycle after it, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: The first byte after a start matches when its upper seven bits equal `{SLAVE_HI, addr_strap}` (default `SLAVE_HI` = 6'h16). Bit 0 is the direction, with 1 meaning read. On a match the block pulls the data line low during the ninth clock pulse.
- R3: On an address mismatch the block never pulls the data line low and never writes a register until the next start. The pointer is also left unchanged.
- R4: In a write transaction the first byte after the address loads the pointer from its low `REG_AW` bits (five by default). Each later byte is received most significant bit first and acknowledged. After its ninth clock it is presented once, as a one-cycle `reg_we` pulse with `reg_addr` equal to the pointer.
- R5: After each written byte the pointer steps by one, and it wraps from `2**REG_AW-1` to 0.
- R6: A read transaction returns the register at the current pointer, most significant bit first. This includes a pointer that was set in an earlier transaction closed by a stop.
- R7: In a read burst, each byte that the master acknowledges is followed by the next register. The pointer steps by one at the end of the eighth bit of every byte sent, and it wraps in the same way as in R5.
- R8: If the master does not acknowledge a read byte, the block releases the data line and keeps it released until the next start or stop.
- R9: A repeated start re-runs address decoding and may change the direction. A pointer loaded before it is still used.
- R10: A start or stop in the middle of a byte aborts that byte, and a partly received byte is never written. The bus then goes to address decoding after a start, or to idle after a stop.
- R11: `sda_oe` only changes while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 1 | Lowest bit of the slave address |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| reg_addr | output | REG_AW | Register bank address, equal to the pointer |
| reg_wdata | output | 8 | Byte to write into the register bank |
| reg_we | output | 1 | One-cycle write strobe for the register bank |
| reg_rdata | input | 8 | Register bank contents at `reg_addr`, combinational |

## Verification
The falling edge that ends an acknowledge clock also starts the next byte. In a read burst, that same edge loads the register selected by a pointer that stepped only a few bus phases earlier. In a write, it commits a byte while the pointer is about to step. Bursts that cross the top of the register space provoke both cases, and the bench judges them against a behavioural register image and a queue of expected writes that is checked on every clock. A second collision is a start or stop that arrives inside a byte. The bus sequence that forms the condition also produces a clock rise, which the block takes as a data bit just before the condition. The bench sends truncated bytes followed by a stop and by a repeated start, and it checks that no write appears and that the pointer keeps its value.

// File: rtl/smbp_pkg.sv
package smbp_pkg;

    localparam int BYTE_W   = 8;
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int N_LINES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } smbp_state_e;

    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } smbp_bus_ev_t;

    function automatic logic smbp_addr_hit(
        input logic [BYTE_W-1:0] rx_byte,
        input logic [5:0]        hi_bits,
        input logic              strap
    );
        return rx_byte[BYTE_W-1:1] == {hi_bits, strap};
    endfunction

endpackage

// File: rtl/smbp_line_sync.sv
module smbp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic dout_prev
);
    // One extra stage beyond the synchronizer gives the previous sample.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign dout      = chain[STAGES-1];
    assign dout_prev = chain[STAGES];

endmodule

// File: rtl/smbp_cond_detect.sv
module smbp_cond_detect
    import smbp_pkg::*;
(
    input  logic [N_LINES-1:0] now_v,
    input  logic [N_LINES-1:0] prev_v,
    output smbp_bus_ev_t       ev
);
    logic scl_n, scl_p, sda_n, sda_p;

    assign scl_n = now_v[LINE_SCL];
    assign scl_p = prev_v[LINE_SCL];
    assign sda_n = now_v[LINE_SDA];
    assign sda_p = prev_v[LINE_SDA];

    always_comb begin
        ev.scl_hi   = scl_n;
        ev.scl_rise = scl_n & ~scl_p;
        ev.scl_fall = ~scl_n & scl_p;
        ev.sda      = sda_n;
        ev.start    = scl_n & scl_p & sda_p & ~sda_n;
        ev.stop     = scl_n & scl_p & ~sda_p & sda_n;
    end

endmodule

// File: rtl/smbp_engine.sv
module smbp_engine
    import smbp_pkg::*;
#(
    parameter logic [5:0] SLAVE_HI = 6'h16,
    parameter int         REG_AW   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  smbp_bus_ev_t       ev,
    input  logic               addr_strap,
    input  logic [BYTE_W-1:0]  reg_rdata,
    output logic               sda_oe,
    output logic [REG_AW-1:0]  reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we
);
    localparam logic [REG_AW-1:0] PTR_ONE  = REG_AW'(1);
    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    smbp_state_e          state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 rnw;
    logic                 first_byte;
    logic                 master_nak;
    logic                 oe_q;
    logic                 we_q;
    logic [BYTE_W-1:0]    wdata_q;
    logic [REG_AW-1:0]    ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            rnw        <= 1'b0;
            first_byte <= 1'b0;
            master_nak <= 1'b0;
            oe_q       <= 1'b0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            ptr        <= '0;
        end else begin
            we_q <= 1'b0;
            if (we_q) ptr <= ptr + PTR_ONE;

            if (ev.stop) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_RX: begin
                        if (ev.scl_rise && bit_cnt != CNT_FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end else if (ev.scl_fall && bit_cnt == CNT_FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (smbp_addr_hit(shreg, SLAVE_HI, addr_strap)) begin
                                    state      <= ST_ADDR_ACK;
                                    oe_q       <= 1'b1;
                                    rnw        <= shreg[0];
                                    first_byte <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state <= ST_RX_ACK;
                                oe_q  <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (rnw) begin
                                state <= ST_TX;
                                shreg <= reg_rdata;
                                oe_q  <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                state <= ST_RX;
                                oe_q  <= 1'b0;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            state <= ST_RX;
                            oe_q  <= 1'b0;
                            if (first_byte) begin
                                ptr        <= shreg[REG_AW-1:0];
                                first_byte <= 1'b0;
                            end else begin
                                we_q    <= 1'b1;
                                wdata_q <= shreg;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt == CNT_LAST) begin
                                state   <= ST_TX_ACK;
                                oe_q    <= 1'b0;
                                bit_cnt <= '0;
                                ptr     <= ptr + PTR_ONE;
                            end else begin
                                bit_cnt <= bit_cnt + CNT_ONE;
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                oe_q    <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            master_nak <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (!master_nak) begin
                                state   <= ST_TX;
                                shreg   <= reg_rdata;
                                oe_q    <= ~reg_rdata[BYTE_W-1];
                                bit_cnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                                oe_q  <= 1'b0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign reg_addr  = ptr;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    // R11: the pull-down only moves in the cycle after the clock line was low
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(ev.scl_hi));

    // R4: each committed byte is a single strobe
    p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R5: the pointer steps (with wrap) right after a write strobe
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_addr == $past(reg_addr) + PTR_ONE));

    // R9: any start re-arms address decoding
    p_start_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && bit_cnt == '0));

    // R10: a stop always leaves the bus released and writes nothing
    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_oe && !reg_we));

    // R8: a refused read byte ends the transfer with the line released
    p_nak_release_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK && ev.scl_fall && master_nak && !ev.start && !ev.stop)
        |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/smbp_slave.sv
module smbp_slave
    import smbp_pkg::*;
#(
    parameter logic [5:0] SLAVE_HI    = 6'h16,
    parameter int         REG_AW      = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_strap,
    output logic               sda_oe,
    output logic [REG_AW-1:0]  reg_addr,
    output logic [7:0]         reg_wdata,
    output logic               reg_we,
    input  logic [7:0]         reg_rdata
);
    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] now_v;
    logic [N_LINES-1:0] prev_v;
    smbp_bus_ev_t       ev;

    assign raw_v[LINE_SDA] = sda_i;
    assign raw_v[LINE_SCL] = scl_i;

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_sync
        smbp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .din       (raw_v[gi]),
            .dout      (now_v[gi]),
            .dout_prev (prev_v[gi])
        );
    end

    smbp_cond_detect u_cond (
        .now_v  (now_v),
        .prev_v (prev_v),
        .ev     (ev)
    );

    smbp_engine #(
        .SLAVE_HI (SLAVE_HI),
        .REG_AW   (REG_AW)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .addr_strap (addr_strap),
        .reg_rdata  (reg_rdata),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we)
    );

endmodule

// File: tb/smbp_slave_tb_top.sv
module smbp_slave_tb_top;

    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;
    localparam int QTR    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_strap = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [REG_AW-1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic reg_we;
    logic [7:0] reg_rdata;

    logic [7:0] bank    [NREG];
    logic [7:0] exp_mem [NREG];
    int wexp[$];
    int n_chk = 0;
    int n_fail = 0;
    int quiet_hits = 0;
    bit quiet = 1'b0;
    int wx;
    bit ack;
    logic [7:0] rd;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    smbp_slave #(.SLAVE_HI(6'h16), .REG_AW(REG_AW), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_strap (addr_strap),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata)
    );

    always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of the register write port and the quiet window
    always @(negedge clk) begin
        if (!rst) begin
            if (quiet && sda_oe) quiet_hits++;
            if (reg_we) begin
                if (wexp.size() == 0) begin
                    chk(1'b0, "R10 unexpected register write", int'({reg_addr, reg_wdata}), 0);
                end else begin
                    wx = wexp.pop_front();
                    chk(int'({reg_addr, reg_wdata}) == wx, "R4 write port address/data",
                        int'({reg_addr, reg_wdata}), wx);
                end
            end
        end
    end

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] b, output bit got_ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        got_ack = (sda_bus == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic read_byte(output logic [7:0] d, input bit mack);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            d = {d[6:0], sda_bus};
            wq();
            scl_m = 1'b0; wq();
        end
        send_bit(!mack);
    endtask

    task automatic expect_write(input int a, input logic [7:0] d);
        wexp.push_back((a << 8) | int'(d));
        exp_mem[a] = d;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            bank[i]    = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 outputs in reset", {sda_oe, reg_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_addr == '0, "R1 state after reset",
            int'({sda_oe, reg_we, reg_addr}), 0);
        wq();

        // Single write, strap = 1 (address 0x2D)
        bus_start();
        write_byte(8'h5A, ack); chk(ack, "R2 address ack strap=1", ack, 1);
        write_byte(8'h05, ack); chk(ack, "R4 pointer byte ack", ack, 1);
        expect_write(5, 8'hA5);
        write_byte(8'hA5, ack); chk(ack, "R4 data byte ack", ack, 1);
        bus_stop(); wq();
        chk(reg_addr == 6, "R5 pointer after single write", reg_addr, 6);

        // Bare read: pointer kept across stop, then refused byte
        bus_start();
        write_byte(8'h5B, ack); chk(ack, "R2 read address ack", ack, 1);
        read_byte(rd, 1'b0);
        chk(rd == exp_mem[6], "R6 read at retained pointer", rd, exp_mem[6]);
        quiet_hits = 0; quiet = 1'b1;
        wq(); wq();
        bus_stop();
        quiet = 1'b0;
        chk(quiet_hits == 0, "R8 line released after master nack", quiet_hits, 0);

        // Pointer write, repeated start, read burst
        bus_start();
        write_byte(8'h5A, ack);
        write_byte(8'h03, ack); chk(ack, "R9 pointer before restart", ack, 1);
        bus_start();
        write_byte(8'h5B, ack); chk(ack, "R9 address ack after restart", ack, 1);
        for (int i = 0; i < 3; i++) begin
            read_byte(rd, i != 2);
            chk(rd == exp_mem[3 + i], "R7 read burst byte", rd, exp_mem[3 + i]);
        end
        bus_stop(); wq();
        chk(reg_addr == 6, "R7 pointer after read burst", reg_addr, 6);

        // Write burst across the top of the register space
        bus_start();
        write_byte(8'h5A, ack);
        write_byte(8'h1E, ack);
        expect_write(30, 8'h11);
        expect_write(31, 8'h22);
        expect_write(0, 8'h33);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        write_byte(8'h33, ack); chk(ack, "R4 burst byte ack", ack, 1);
        bus_stop(); wq();
        chk(reg_addr == 1, "R5 pointer wrap on write", reg_addr, 1);

        // Read burst across the wrap
        bus_start();
        write_byte(8'h5A, ack);
        write_byte(8'h1F, ack);
        bus_start();
        write_byte(8'h5B, ack);
        read_byte(rd, 1'b1);
        chk(rd == exp_mem[31], "R7 read before wrap", rd, exp_mem[31]);
        read_byte(rd, 1'b0);
        chk(rd == exp_mem[0], "R7 read after wrap", rd, exp_mem[0]);
        bus_stop(); wq();

        // Strap = 0: address 0x2C matches
        addr_strap = 1'b0; wq();
        bus_start();
        write_byte(8'h58, ack); chk(ack, "R2 address ack strap=0", ack, 1);
        write_byte(8'h09, ack);
        expect_write(9, 8'h66);
        write_byte(8'h66, ack);
        bus_stop(); wq();

        // Mismatch: address 0x2D while strap = 0
        bus_start();
        quiet_hits = 0; quiet = 1'b1;
        write_byte(8'h5A, ack); chk(!ack, "R3 no ack on mismatch", ack, 0);
        write_byte(8'h02, ack); chk(!ack, "R3 no ack on later byte", ack, 0);
        write_byte(8'h77, ack);
        bus_stop();
        quiet = 1'b0;
        chk(quiet_hits == 0, "R3 line untouched on mismatch", quiet_hits, 0);
        chk(reg_addr == 10, "R3 pointer untouched on mismatch", reg_addr, 10);
        addr_strap = 1'b1; wq();

        // Stop inside a data byte
        bus_start();
        write_byte(8'h5A, ack);
        write_byte(8'h14, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop(); wq();
        chk(reg_addr == 20, "R10 pointer after aborted byte", reg_addr, 20);
        chk(wexp.size() == 0, "R10 nothing pending after stop abort", wexp.size(), 0);

        // Repeated start inside a data byte, then read the untouched register
        bus_start();
        write_byte(8'h5A, ack);
        write_byte(8'h0C, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_start();
        write_byte(8'h5B, ack); chk(ack, "R10 address ack after mid-byte restart", ack, 1);
        read_byte(rd, 1'b0);
        chk(rd == exp_mem[12], "R10 register not written by partial byte", rd, exp_mem[12]);
        bus_stop(); wq(); wq();

        chk(wexp.size() == 0, "R4 all expected writes seen", wexp.size(), 0);
        finish_run();
    end

endmodule